// File: doc/BRIEF.md
# Polled Output Port Controller

This block puts a single byte-wide output device behind a small register port that a processor reads and writes. Software checks a busy flag in the status register and, when it is clear, writes a byte into the data register. The controller captures the byte, sets busy, and offers the byte to the downstream device on a valid/ready handshake. When the device accepts the byte, the controller clears busy and sets a sticky done flag.

The done flag can drive an interrupt line when software sets an enable bit, so the processor can wait for the interrupt instead of polling. A data write that arrives while a byte is still in flight is dropped, and a sticky overrun flag records it. Both sticky flags are cleared by writing 1 to their own bit.

Top module: `pio_out_port`

## Requirements
- R1: After reset, dev_valid and irq are 0, and the status word reads 0 (busy, interrupt enable, done and overrun all clear).
- R2: A write to offset 0 while busy is 0 latches the byte. From the next cycle, dev_valid is 1, dev_data carries the byte and status bit 0 (busy) reads 1.
- R3: While dev_valid is 1 and dev_ready is 0, dev_valid stays 1 and dev_data does not change.
- R4: In the cycle after a clock edge that sees dev_valid and dev_ready both 1, dev_valid is 0, busy reads 0 and status bit 2 (done) reads 1.
- R5: A write to offset 0 while busy is 1 leaves dev_data and the offset 0 readback unchanged. It sets status bit 3 (overrun) from the next cycle.
- R6: Writing 1 to status bit 2 at offset 1 clears done, and writing 0 there leaves it unchanged. If the same edge also completes a handshake, done stays 1.
- R7: Writing 1 to status bit 3 at offset 1 clears overrun, and writing 0 there leaves it unchanged.
- R8: Status bit 1 (interrupt enable) takes the value of bit 1 of every write to offset 1. irq is 1 exactly when done and interrupt enable are both 1.
- R9: Offset 0 reads back the last byte that was accepted. Offset 1 reads the status word with bits above 3 at zero. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from bus_addr |
| dev_valid | output | 1 | Byte offered to the device |
| dev_data | output | DATA_W | Byte to the device |
| dev_ready | input | 1 | Device accepts the byte |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can land on the same edge. In the first, the device handshake sets done while software writes 1 to the done bit to clear it. In the second, software writes a new data byte in the very cycle the current byte is accepted. A directed step creates the first case: done is already set, and the handshake is released in the same cycle as the clear. The expected result is that done stays 1 and irq stays high. The second case, along with many other overlaps, comes from random dev_ready and random register traffic. A cycle-level bench model predicts the result: the late write counts as an overrun, and the byte it carries is not sent.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int OFF_DATA   = 0;
   localparam int OFF_STATUS = 1;
   localparam int BIT_BUSY   = 0;
   localparam int BIT_IE     = 1;
   localparam int BIT_DONE   = 2;
   localparam int BIT_OVR    = 3;
   localparam int STATUS_W   = 4;
endpackage

// File: rtl/pio_xfer_engine.sv
module pio_xfer_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              dev_ready,
   output logic              dev_valid,
   output logic [DATA_W-1:0] dev_data,
   output logic              xfer_done
);
   assign xfer_done = dev_valid && dev_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_valid <= 1'b0;
         dev_data  <= '0;
      end else if (load && !dev_valid) begin
         dev_valid <= 1'b1;
         dev_data  <= load_data;
      end else if (xfer_done) begin
         dev_valid <= 1'b0;
      end
   end

   // R3: byte held steady while the device stalls
   assert_hold_while_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)));

   // R4: offer withdrawn after acceptance
   assert_drop_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && dev_ready) |=> !dev_valid);
endmodule

// File: rtl/pio_status_regs.sv
module pio_status_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_done,
   input  logic ovr_set,
   input  logic ctl_wr,
   input  logic ie_val,
   input  logic clr_done,
   input  logic clr_ovr,
   output logic ie,
   output logic done,
   output logic ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie   <= 1'b0;
         done <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (ctl_wr) ie <= ie_val;
         if (xfer_done)                done <= 1'b1;
         else if (ctl_wr && clr_done)  done <= 1'b0;
         if (ovr_set)                  ovr <= 1'b1;
         else if (ctl_wr && clr_ovr)   ovr <= 1'b0;
      end
   end

   // R4 and R6: a completion always leaves done set, even against a clear
   assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> done);

   // R6: clear without a competing completion empties done
   assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && clr_done && !xfer_done) |=> !done);

   // R7: overrun clear works
   assert_ovr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && clr_ovr && !ovr_set) |=> !ovr);
endmodule

// File: rtl/pio_out_port.sv
module pio_out_port #(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 2,
   parameter bit IRQ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              dev_valid,
   output logic [DATA_W-1:0] dev_data,
   input  logic              dev_ready,
   output logic              irq
);
   import pio_pkg::*;

   initial begin
      if (DATA_W < 1 || DATA_W > BUS_W)
         $error("pio_out_port: DATA_W must lie in 1..BUS_W");
      if (BUS_W < STATUS_W)
         $error("pio_out_port: BUS_W too narrow for status word");
      if (ADDR_W < 1)
         $error("pio_out_port: ADDR_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

   logic wr_data, wr_status, busy, xfer_done;
   logic ie, done, ovr;
   logic [BUS_W-1:0] status_word;

   assign wr_data   = bus_sel && bus_we && (bus_addr == A_DATA);
   assign wr_status = bus_sel && bus_we && (bus_addr == A_STATUS);

   pio_xfer_engine #(.DATA_W(DATA_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_data),
      .load_data (bus_wdata[DATA_W-1:0]),
      .dev_ready (dev_ready),
      .dev_valid (dev_valid),
      .dev_data  (dev_data),
      .xfer_done (xfer_done)
   );

   assign busy = dev_valid;

   pio_status_regs u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_done (xfer_done),
      .ovr_set   (wr_data && busy),
      .ctl_wr    (wr_status),
      .ie_val    (bus_wdata[BIT_IE]),
      .clr_done  (bus_wdata[BIT_DONE]),
      .clr_ovr   (bus_wdata[BIT_OVR]),
      .ie        (ie),
      .done      (done),
      .ovr       (ovr)
   );

   always_comb begin
      status_word           = '0;
      status_word[BIT_BUSY] = busy;
      status_word[BIT_IE]   = ie;
      status_word[BIT_DONE] = done;
      status_word[BIT_OVR]  = ovr;
   end

   always_comb begin
      if (bus_addr == A_DATA)        bus_rdata = BUS_W'(dev_data);
      else if (bus_addr == A_STATUS) bus_rdata = status_word;
      else                           bus_rdata = '0;
   end

   generate
      if (IRQ_EN) begin : g_irq
         assign irq = done && ie;
      end else begin : g_no_irq
         assign irq = 1'b0;
      end
   endgenerate

   // R5: a write during a transfer is dropped and flagged
   assert_busy_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy) |=> (ovr && $stable(dev_data)));

   // R2: an idle write starts a transfer
   assert_idle_write_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !busy) |=> dev_valid);
endmodule

// File: tb/pio_out_port_test.sv
module pio_out_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       dev_valid, dev_ready = 1'b0, irq;
   logic [7:0] dev_data;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   // bench model of the register state
   logic       m_valid = 0, m_ie = 0, m_done = 0, m_ovr = 0;
   logic [7:0] m_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_out_port uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready), .irq(irq)
   );

   always @(posedge clk) begin
      logic hs, w0, w1;
      if (!rst_n) begin
         m_valid = 0; m_ie = 0; m_done = 0; m_ovr = 0; m_data = '0;
      end else begin
         hs = m_valid && dev_ready;
         w0 = bus_sel && bus_we && bus_addr == 2'd0;
         w1 = bus_sel && bus_we && bus_addr == 2'd1;
         if (w0 && m_valid) m_ovr = 1;
         else if (w1 && bus_wdata[3]) m_ovr = 0;
         if (hs) m_done = 1;
         else if (w1 && bus_wdata[2]) m_done = 0;
         if (w1) m_ie = bus_wdata[1];
         if (w0 && !m_valid) begin m_valid = 1; m_data = bus_wdata; end
         else if (hs) m_valid = 0;
      end
   end

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      if (a == 2'd0) return m_data;
      if (a == 2'd1) return {4'b0, m_ovr, m_done, m_ie, m_valid};
      return 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle: check registered outputs, apply inputs, check readback
   task automatic cyc(input logic sel, input logic we, input logic [1:0] a,
                      input logic [7:0] wd, input logic rdy);
      @(negedge clk);
      check("R2 R4 dev_valid", {7'b0, dev_valid}, {7'b0, m_valid});
      check("R3 dev_data", dev_data, m_data);
      check("R8 irq", {7'b0, irq}, {7'b0, m_done & m_ie});
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; dev_ready = rdy;
      #1;
      if (sel && !we) check("R9 readback", bus_rdata, exp_rd(a));
   endtask

   task automatic rd(input logic [1:0] a, input logic rdy);
      cyc(1, 0, a, 8'h00, rdy);
   endtask

   initial begin
      int cnt = 0;
      while (!finished && cnt < WATCHDOG) begin
         @(posedge clk);
         cnt++;
      end
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd1, 0);
      check("R1 status after reset", bus_rdata, 8'h00);
      check("R1 dev_valid after reset", {7'b0, dev_valid}, 8'h00);
      // R2 idle write, R3 stall
      cyc(1, 1, 2'd0, 8'hA5, 0);
      rd(2'd1, 0);
      check("R2 busy set", bus_rdata, 8'h01);
      check("R2 dev_data", dev_data, 8'hA5);
      rd(2'd0, 0); rd(2'd0, 0);
      check("R3 held data", dev_data, 8'hA5);
      // R5 write while busy
      cyc(1, 1, 2'd0, 8'h3C, 0);
      rd(2'd1, 0);
      check("R5 overrun flag", bus_rdata, 8'h09);
      check("R5 data kept", dev_data, 8'hA5);
      // R4 handshake
      rd(2'd1, 1);
      rd(2'd1, 0);
      check("R4 done and idle", bus_rdata, 8'h0C);
      // R8 enable interrupt, R7 clear overrun
      cyc(1, 1, 2'd1, 8'h0A, 0);
      rd(2'd1, 0);
      check("R7 overrun cleared, R8 ie", bus_rdata, 8'h06);
      check("R8 irq high", {7'b0, irq}, 8'h01);
      // R6 collision: new transfer completes while done is being cleared
      cyc(1, 1, 2'd0, 8'h5A, 0);
      cyc(1, 1, 2'd1, 8'h06, 1);
      rd(2'd1, 0);
      check("R6 set wins over clear", bus_rdata, 8'h06);
      cyc(1, 1, 2'd1, 8'h02, 0);
      rd(2'd1, 0);
      check("R6 write 0 keeps done", bus_rdata, 8'h06);
      cyc(1, 1, 2'd1, 8'h04, 0);
      rd(2'd1, 0);
      check("R6 done cleared, R8 ie off", bus_rdata, 8'h00);
      // R9 other offsets
      cyc(1, 1, 2'd2, 8'hFF, 0);
      cyc(1, 1, 2'd3, 8'hFF, 0);
      rd(2'd2, 0);
      check("R9 offset 2 reads 0", bus_rdata, 8'h00);
      rd(2'd0, 0);
      check("R9 last byte", bus_rdata, 8'h5A);
      rd(2'd1, 0);
      check("R9 status untouched", bus_rdata, 8'h00);
      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] a;
         a = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 3) == 0) a = 2'd1;
         cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
             8'($urandom), 1'($urandom_range(0, 2) == 0));
      end
      cyc(0, 0, 2'd0, 8'h00, 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule